// File: doc/BRIEF.md
# Receive Ring Address Generator

This block sits on one receive stream of a network interface. It cuts the incoming 64-bit payload stream into packets of a configured number of words. In front of each packet it places one header word. The header carries the destination virtual address for that packet, the port number and a host-or-GPU target flag. The receive buffers form a ring in host or GPU memory. The ring is described by a base address, a buffer size in bytes and a buffer count, and the block fills these buffers one after another.

Each packet goes at the current fill offset of the current buffer. A packet that would not fit in what is left of that buffer closes it, and the packet then goes at offset 0 of the next buffer. After the last buffer the ring returns to buffer 0.

A buffer is also closed when the packet that fills it exactly has been fully accepted. A partly filled buffer is closed when it has held data for a configured number of cycles and no packet is in progress. Each close produces a one-cycle event carrying the buffer's index and the number of bytes written into it. Address translation, DMA and routing are done by other blocks.

Top module: `rx_ring_addr_gen`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `out_valid`, `ev_valid` and `in_ready` are low.
- R2: Each packet begins with a header word that has `out_sop` set. With the default widths, its bits are laid out as follows:
  - bits [39:0] hold the destination address;
  - bits [43:40] hold `cfg_port`;
  - bit [44] holds `cfg_to_gpu`;
  - bits [52:45] hold `cfg_pkt_words`;
  - all other bits are 0.
- R3: The destination address equals `cfg_base` + (buffer index × `cfg_buf_bytes`) + fill offset, where the fill offset is the number of bytes already placed in the current buffer.
- R4: After the header come exactly `cfg_pkt_words` payload words, in the order they were accepted on the input. The last of them has `out_eop` set, and each packet adds `cfg_pkt_words`×8 bytes to the fill offset.
- R5: If the current buffer holds data and fill offset + packet bytes would exceed `cfg_buf_bytes`, two things happen:
  - an event reports that buffer's index and its fill;
  - the packet is placed at offset 0 of the next buffer.
- R6: When the last payload word of a packet that fills a buffer exactly has been accepted, an event reports that buffer's index and `cfg_buf_bytes`, and the next packet goes at offset 0 of the next buffer.
- R7: The buffer index after `cfg_buf_count`-1 is 0, and the index never reaches `cfg_buf_count`.
- R8: A buffer that holds data is closed with an event reporting its index and fill when two conditions meet: it has held data for at least `cfg_timeout` cycles, and no packet is in progress. An empty buffer never produces an event, however long the input stays idle.
- R9: While `out_valid` is high and `out_ready` is low, the output word and its flags stay unchanged, and no input word is lost.
- R10: `ev_valid` is a single-cycle pulse, and `ev_bytes` is never 0 when it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_base | input | ADDR_W | Virtual address of buffer 0 |
| cfg_buf_bytes | input | BYTES_W | Size of each buffer in bytes |
| cfg_buf_count | input | IDX_W | Number of buffers in the ring (at least 1) |
| cfg_pkt_words | input | LEN_W | Payload words per packet (at least 1, 8× this no larger than the buffer) |
| cfg_port | input | PORT_W | Port number placed in the header |
| cfg_to_gpu | input | 1 | Target flag placed in the header (1 = GPU memory) |
| cfg_timeout | input | TMO_W | Cycles a partly filled buffer may hold data before it is closed |
| in_valid | input | 1 | Payload word present |
| in_ready | output | 1 | Payload word accepted this cycle |
| in_data | input | 64 | Payload word |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Output word taken by the next stage |
| out_data | output | 64 | Header or payload word |
| out_sop | output | 1 | Output word is a header |
| out_eop | output | 1 | Output word is the last payload word of a packet |
| ev_valid | output | 1 | A buffer was closed |
| ev_index | output | IDX_W | Index of the closed buffer |
| ev_bytes | output | BYTES_W | Bytes written into the closed buffer |

## Verification
The assertions check four things on every cycle: the buffer index stays below the count, and the fill never exceeds the buffer size. The output stays stable under backpressure, and every event is a one-cycle pulse with a nonzero byte count. The bench scenarios are what show that the addresses are correct, that packets roll over to the next buffer, that exact fills close a buffer, and that the ring wraps. They likewise show the timeout close, the silence of an empty buffer and the payload order. To do this, the bench drives a small ring with several packet sizes, with and without backpressure, and recomputes every header and event arithmetically.

// File: rtl/rx_ring_pkg.sv
package rx_ring_pkg;
  localparam int WORD_W = 64;
  localparam int BYTE_SHIFT = 3;

  typedef enum logic {
    FR_IDLE = 1'b0,
    FR_DATA = 1'b1
  } framer_state_e;
endpackage

// File: rtl/ring_cursor.sv
module ring_cursor #(
  parameter int ADDR_W  = 40,
  parameter int BYTES_W = 20,
  parameter int IDX_W   = 8,
  parameter int LEN_W   = 8,
  parameter int TMO_W   = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  cfg_base,
  input  logic [BYTES_W-1:0] cfg_buf_bytes,
  input  logic [IDX_W-1:0]   cfg_buf_count,
  input  logic [LEN_W-1:0]   cfg_pkt_words,
  input  logic [TMO_W-1:0]   cfg_timeout,
  input  logic               idle,
  input  logic               start,
  input  logic               finish,
  output logic               hold,
  output logic [ADDR_W-1:0]  place_addr,
  output logic               ev_valid,
  output logic [IDX_W-1:0]   ev_index,
  output logic [BYTES_W-1:0] ev_bytes
);
  import rx_ring_pkg::*;

  localparam int SUM_W = BYTES_W + 1;

  logic [IDX_W-1:0]   idx_q;
  logic [BYTES_W-1:0] fill_q;
  logic [TMO_W-1:0]   age_q;
  logic [ADDR_W-1:0]  start_q;

  logic [SUM_W-1:0]   pkt_bytes;
  logic [SUM_W-1:0]   fill_sum;
  logic               need_roll;
  logic               last_buf;
  logic [IDX_W-1:0]   next_idx;
  logic [ADDR_W-1:0]  next_start;
  logic               tmo_hit;
  logic               full_hit;

  always_comb begin
    pkt_bytes  = SUM_W'(cfg_pkt_words) << BYTE_SHIFT;
    fill_sum   = {1'b0, fill_q} + pkt_bytes;
    need_roll  = (fill_q != '0) && (fill_sum > {1'b0, cfg_buf_bytes});
    last_buf   = (idx_q == cfg_buf_count - IDX_W'(1));
    next_idx   = last_buf ? '0 : idx_q + IDX_W'(1);
    next_start = last_buf ? cfg_base : start_q + ADDR_W'(cfg_buf_bytes);
    place_addr = need_roll ? next_start : start_q + ADDR_W'(fill_q);
    tmo_hit    = idle && (fill_q != '0) && (age_q >= cfg_timeout);
    full_hit   = finish && (fill_q == cfg_buf_bytes);
    hold       = tmo_hit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q    <= '0;
      fill_q   <= '0;
      age_q    <= '0;
      start_q  <= cfg_base;
      ev_valid <= 1'b0;
      ev_index <= '0;
      ev_bytes <= '0;
    end else begin
      ev_valid <= 1'b0;
      if (fill_q == '0) begin
        age_q <= '0;
      end else if (age_q < cfg_timeout) begin
        age_q <= age_q + TMO_W'(1);
      end

      if (tmo_hit || full_hit || (start && need_roll)) begin
        ev_valid <= 1'b1;
        ev_index <= idx_q;
        ev_bytes <= fill_q;
        idx_q    <= next_idx;
        start_q  <= next_start;
        age_q    <= '0;
      end

      if (tmo_hit || full_hit) begin
        fill_q <= '0;
      end else if (start) begin
        fill_q <= need_roll ? BYTES_W'(pkt_bytes) : BYTES_W'(fill_sum);
      end
    end
  end

  // R7: the ring index stays inside the configured count
  assert_idx_range_R7: assert property (@(posedge clk) disable iff (rst)
    idx_q < cfg_buf_count);

  // R5: the fill never runs past the end of a buffer
  assert_fill_bound_R5: assert property (@(posedge clk) disable iff (rst)
    fill_q <= cfg_buf_bytes);

  // R10: one-cycle events with a nonzero byte count
  assert_ev_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    ev_valid |=> !ev_valid);
  assert_ev_nonzero_R10: assert property (@(posedge clk) disable iff (rst)
    ev_valid |-> (ev_bytes != '0));
endmodule

// File: rtl/pkt_framer.sv
module pkt_framer #(
  parameter int LEN_W = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [LEN_W-1:0]              cfg_pkt_words,
  input  logic                          hold,
  input  logic [rx_ring_pkg::WORD_W-1:0] hdr_word,
  input  logic                          in_valid,
  output logic                          in_ready,
  input  logic [rx_ring_pkg::WORD_W-1:0] in_data,
  output logic                          out_valid,
  input  logic                          out_ready,
  output logic [rx_ring_pkg::WORD_W-1:0] out_data,
  output logic                          out_sop,
  output logic                          out_eop,
  output logic                          idle,
  output logic                          start,
  output logic                          finish
);
  import rx_ring_pkg::*;

  framer_state_e     state_q;
  logic [LEN_W-1:0]  left_q;
  logic              slot_free;
  logic              take;

  always_comb begin
    slot_free = !out_valid || out_ready;
    idle      = (state_q == FR_IDLE);
    start     = idle && in_valid && slot_free && !hold;
    in_ready  = (state_q == FR_DATA) && slot_free;
    take      = in_ready && in_valid;
    finish    = take && (left_q == LEN_W'(1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= FR_IDLE;
      left_q    <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_sop   <= 1'b0;
      out_eop   <= 1'b0;
    end else if (start) begin
      out_valid <= 1'b1;
      out_data  <= hdr_word;
      out_sop   <= 1'b1;
      out_eop   <= 1'b0;
      left_q    <= cfg_pkt_words;
      state_q   <= FR_DATA;
    end else if (take) begin
      out_valid <= 1'b1;
      out_data  <= in_data;
      out_sop   <= 1'b0;
      out_eop   <= finish;
      left_q    <= left_q - LEN_W'(1);
      if (finish) state_q <= FR_IDLE;
    end else if (slot_free) begin
      out_valid <= 1'b0;
    end
  end

  // R9: a stalled word is held unchanged
  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) &&
                                   $stable(out_sop) && $stable(out_eop)));
endmodule

// File: rtl/rx_ring_addr_gen.sv
module rx_ring_addr_gen #(
  parameter int ADDR_W  = 40,
  parameter int BYTES_W = 20,
  parameter int IDX_W   = 8,
  parameter int LEN_W   = 8,
  parameter int PORT_W  = 4,
  parameter int TMO_W   = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  cfg_base,
  input  logic [BYTES_W-1:0] cfg_buf_bytes,
  input  logic [IDX_W-1:0]   cfg_buf_count,
  input  logic [LEN_W-1:0]   cfg_pkt_words,
  input  logic [PORT_W-1:0]  cfg_port,
  input  logic               cfg_to_gpu,
  input  logic [TMO_W-1:0]   cfg_timeout,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [63:0]        in_data,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [63:0]        out_data,
  output logic               out_sop,
  output logic               out_eop,
  output logic               ev_valid,
  output logic [IDX_W-1:0]   ev_index,
  output logic [BYTES_W-1:0] ev_bytes
);
  import rx_ring_pkg::*;

  localparam int PORT_LSB = ADDR_W;
  localparam int TGT_BIT  = ADDR_W + PORT_W;
  localparam int LEN_LSB  = TGT_BIT + 1;

  logic              f_idle;
  logic              f_start;
  logic              f_finish;
  logic              c_hold;
  logic [ADDR_W-1:0] c_addr;
  logic [WORD_W-1:0] hdr_word;

  always_comb begin
    hdr_word                     = '0;
    hdr_word[ADDR_W-1:0]         = c_addr;
    hdr_word[PORT_LSB +: PORT_W] = cfg_port;
    hdr_word[TGT_BIT]            = cfg_to_gpu;
    hdr_word[LEN_LSB +: LEN_W]   = cfg_pkt_words;
  end

  ring_cursor #(
    .ADDR_W (ADDR_W),
    .BYTES_W(BYTES_W),
    .IDX_W  (IDX_W),
    .LEN_W  (LEN_W),
    .TMO_W  (TMO_W)
  ) u_cursor (
    .clk          (clk),
    .rst          (rst),
    .cfg_base     (cfg_base),
    .cfg_buf_bytes(cfg_buf_bytes),
    .cfg_buf_count(cfg_buf_count),
    .cfg_pkt_words(cfg_pkt_words),
    .cfg_timeout  (cfg_timeout),
    .idle         (f_idle),
    .start        (f_start),
    .finish       (f_finish),
    .hold         (c_hold),
    .place_addr   (c_addr),
    .ev_valid     (ev_valid),
    .ev_index     (ev_index),
    .ev_bytes     (ev_bytes)
  );

  pkt_framer #(
    .LEN_W(LEN_W)
  ) u_framer (
    .clk          (clk),
    .rst          (rst),
    .cfg_pkt_words(cfg_pkt_words),
    .hold         (c_hold),
    .hdr_word     (hdr_word),
    .in_valid     (in_valid),
    .in_ready     (in_ready),
    .in_data      (in_data),
    .out_valid    (out_valid),
    .out_ready    (out_ready),
    .out_data     (out_data),
    .out_sop      (out_sop),
    .out_eop      (out_eop),
    .idle         (f_idle),
    .start        (f_start),
    .finish       (f_finish)
  );

  // R1: nothing is offered in the first cycle after reset
  assert_reset_quiet_R1: assert property (@(posedge clk)
    $fell(rst) |-> (!out_valid && !ev_valid && !in_ready));
endmodule

// File: tb/rx_ring_addr_gen_tb.sv
module rx_ring_addr_gen_tb;
  localparam int  ADDR_W = 40;
  localparam int  BYTES_W = 20;
  localparam int  IDX_W = 8;
  localparam int  LEN_W = 8;
  localparam int  PORT_W = 4;
  localparam int  TMO_W = 16;
  localparam longint BASE = 40'h00_1234_0000;
  localparam int  BS = 64;
  localparam int  NBUF = 3;
  localparam int  TMO = 100;

  logic clk = 0;
  logic rst = 1;
  logic [ADDR_W-1:0]  cfg_base = ADDR_W'(BASE);
  logic [BYTES_W-1:0] cfg_buf_bytes = BYTES_W'(BS);
  logic [IDX_W-1:0]   cfg_buf_count = IDX_W'(NBUF);
  logic [LEN_W-1:0]   cfg_pkt_words = 3;
  logic [PORT_W-1:0]  cfg_port = 4'h5;
  logic               cfg_to_gpu = 1;
  logic [TMO_W-1:0]   cfg_timeout = TMO_W'(TMO);
  logic in_valid = 0;
  logic in_ready;
  logic [63:0] in_data = '0;
  logic out_valid;
  logic out_ready = 1;
  logic [63:0] out_data;
  logic out_sop, out_eop;
  logic ev_valid;
  logic [IDX_W-1:0] ev_index;
  logic [BYTES_W-1:0] ev_bytes;

  rx_ring_addr_gen u_dut (
    .clk(clk), .rst(rst), .cfg_base(cfg_base), .cfg_buf_bytes(cfg_buf_bytes),
    .cfg_buf_count(cfg_buf_count), .cfg_pkt_words(cfg_pkt_words),
    .cfg_port(cfg_port), .cfg_to_gpu(cfg_to_gpu), .cfg_timeout(cfg_timeout),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_sop(out_sop), .out_eop(out_eop), .ev_valid(ev_valid),
    .ev_index(ev_index), .ev_bytes(ev_bytes)
  );

  always #5 clk = ~clk;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  bit bp_mode = 0;
  int cyc = 0;

  // expected output words {sop, eop, data} and expected events {index, bytes}
  logic [65:0] oq[$];
  logic [63:0] eq[$];
  int m_idx = 0;
  int m_fill = 0;
  longint seq = 0;

  task automatic chk(input bit ok, input string rq, input string msg);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s", rq, msg);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    #2 out_ready = !bp_mode || ((cyc % 3) != 0);
  end

  always @(negedge clk) begin
    if (!rst && out_valid && out_ready) begin
      if (oq.size() == 0) begin
        chk(0, "R4", $sformatf("unexpected word act=%h exp=none", out_data));
      end else begin
        logic [65:0] e;
        e = oq.pop_front();
        chk({out_sop, out_eop, out_data} == e, e[65] ? "R2/R3" : "R4",
            $sformatf("word act=%b%b_%h exp=%b%b_%h", out_sop, out_eop, out_data,
                      e[65], e[64], e[63:0]));
      end
    end
    if (!rst && ev_valid) begin
      if (eq.size() == 0) begin
        chk(0, "R8", $sformatf("unexpected event act=%0d/%0d exp=none", ev_index, ev_bytes));
      end else begin
        logic [63:0] e;
        e = eq.pop_front();
        chk({32'(ev_index), 32'(ev_bytes)} == e, "R5/R6/R7",
            $sformatf("event act=%0d/%0d exp=%0d/%0d", ev_index, ev_bytes, e[63:32], e[31:0]));
      end
    end
  end

  function automatic void m_close();
    eq.push_back({32'(m_idx), 32'(m_fill)});
    m_idx = (m_idx == NBUF - 1) ? 0 : m_idx + 1;
    m_fill = 0;
  endfunction

  task automatic send_pkt(input int nw);
    int pb;
    logic [63:0] hdr;
    logic [63:0] words[$];
    pb = nw * 8;
    @(negedge clk);
    cfg_pkt_words = LEN_W'(nw);
    if (m_fill != 0 && m_fill + pb > BS) m_close();
    hdr = '0;
    hdr[39:0] = 40'(BASE + longint'(m_idx) * BS + m_fill);
    hdr[43:40] = cfg_port;
    hdr[44] = cfg_to_gpu;
    hdr[52:45] = 8'(nw);
    oq.push_back({2'b10, hdr});
    for (int w = 0; w < nw; w++) begin
      seq++;
      words.push_back(64'hC0DE_0000_0000_0000 | 64'(seq));
      oq.push_back({1'b0, w == nw - 1, words[w]});
    end
    m_fill += pb;
    if (m_fill == BS) m_close();
    for (int w = 0; w < nw; w++) begin
      in_valid = 1;
      in_data = words[w];
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      @(posedge clk);
      #1;
    end
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic idle_wait(input int n);
    if (n > TMO + 5 && m_fill != 0) m_close();
    repeat (n) @(negedge clk);
  endtask

  task automatic drained(input string rq);
    repeat (20) @(negedge clk);
    chk(oq.size() == 0 && eq.size() == 0, rq,
        $sformatf("pending act=%0d/%0d exp=0/0", oq.size(), eq.size()));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!out_valid && !ev_valid && !in_ready, "R1",
        $sformatf("in reset act=%b%b%b exp=000", out_valid, ev_valid, in_ready));
    rst = 0;
    @(negedge clk);
    chk(!out_valid && !ev_valid && !in_ready, "R1",
        $sformatf("after reset act=%b%b%b exp=000", out_valid, ev_valid, in_ready));

    // R3 R5 R7: 24-byte packets roll over and wrap the 3-buffer ring
    for (int p = 0; p < 7; p++) send_pkt(3);
    drained("R5");
    // R8: partly filled buffer closes on timeout
    idle_wait(TMO + 30);
    drained("R8");
    // R8: empty buffer stays silent
    idle_wait(TMO * 2);
    drained("R8");

    // R6 R9: 16-byte packets fill exactly, under backpressure
    bp_mode = 1;
    cfg_port = 4'hA;
    cfg_to_gpu = 0;
    for (int p = 0; p < 9; p++) send_pkt(2);
    drained("R6");
    idle_wait(TMO + 30);
    drained("R8");

    // R6 R7: packet as large as a buffer, one per buffer
    bp_mode = 0;
    for (int p = 0; p < 4; p++) send_pkt(8);
    drained("R6");
    idle_wait(TMO * 2);
    drained("R8");

    // R2 R4: single-word packets, with backpressure
    bp_mode = 1;
    cfg_port = 4'h3;
    for (int p = 0; p < 10; p++) send_pkt(1);
    drained("R4");
    idle_wait(TMO + 30);
    drained("R8");

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog act=running exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule